// File: doc/BRIEF.md
# Trace Message Capture and Compare

This block handles a repeating trace message that travels one byte per frame in a fixed overhead byte, as used for section or path identification. On the transmit side it returns, on each frame strobe, the next byte of a 64-byte insert buffer and loops over the buffer without end. On the receive side it builds each complete 64-byte incoming message. It checks every message against a 64-byte expected buffer and keeps the most recent distinct message in an extract buffer. The same block can sit on the section trace or on the path trace.

A mismatch flag follows the result of the comparison with hysteresis. It rises only after three complete messages in a row fail the comparison, and it falls only after three in a row pass. Each change of the flag raises a one-cycle event. Software reaches all three buffers and the flag through a simple byte-wide address and data port.

Top module: `trace_monitor`

## Requirements
- R1: After reset, mismatch_o, mismatch_evt_o and tx_byte_o are 0, and every byte of the insert, expected and extract buffers reads as 0.
- R2: Each cycle with tx_stb_i high loads insert[tx_index] into tx_byte_o at that clock edge and advances tx_index, which starts at 0 and wraps from 63 to 0. Without a strobe, tx_byte_o holds its value.
- R3: Register port: reg_addr_i[7:6] selects the target, with 0 for insert, 1 for expected, 2 for extract and 3 for status. reg_addr_i[5:0] is the byte index. reg_rdata_o shows the addressed byte combinationally. Status bit 0 is the mismatch flag and the other status bits are 0. A write with reg_we_i high takes effect at the clock edge.
- R4: Each cycle with rx_stb_i high stores rx_byte_i at rx_index, which starts at 0 after reset and wraps from 63 to 0. A message is complete when the byte at index 63 arrives.
- R5: The extract buffer changes only at the clock edge that completes a message, and only if that message differs from the stored one. The whole message is then copied in at once, so a partial message never shows.
- R6: Writes aimed at the extract buffer (target 2) or at status (target 3) have no effect.
- R7: A complete message that differs from the expected buffer in any byte counts as a mismatch. mismatch_o rises at the edge that completes the third mismatching message in a row.
- R8: mismatch_o falls at the edge that completes the third matching message in a row.
- R9: A message whose verdict agrees with the current flag restarts the count, so verdicts that are not consecutive never change the flag.
- R10: mismatch_evt_o is high for exactly the one cycle after each edge where mismatch_o changes, and is low otherwise.
- R11: If software writes the insert byte that is being sent in the same cycle as tx_stb_i, the old byte goes out. The new byte goes out on the next pass through the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_stb_i | input | 1 | Transmit frame strobe: request the next trace byte |
| tx_byte_o | output | 8 | Trace byte to be inserted |
| rx_stb_i | input | 1 | Receive frame strobe: rx_byte_i is valid |
| rx_byte_i | input | 8 | Received trace byte |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | {target[1:0], byte index[5:0]} |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mismatch_o | output | 1 | Filtered mismatch flag |
| mismatch_evt_o | output | 1 | One-cycle pulse on each flag change |

## Verification
A software write to the insert buffer and a transmit strobe can hit the same entry in the same cycle. The bench runs the transmit index to entry 2 and then, in a single cycle, raises tx_stb_i while writing a new value to entry 2. The scoreboard expects the old byte at that point, then checks each byte of the next full pass, and expects the new byte when entry 2 comes round again. The bench also stops a message halfway and reads the extract buffer, to show that reception and the software read path do not disturb each other.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    BANK_INS  = 2'd0,
    BANK_EXP  = 2'd1,
    BANK_EXT  = 2'd2,
    BANK_STAT = 2'd3
  } bank_e;
endpackage

// File: rtl/trace_buf.sv
module trace_buf #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [IW-1:0] ridx_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_i && widx_i == IW'(i)) mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/trace_tx.sv
module trace_tx #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  output logic [IW-1:0] idx_o,
  input  logic [W-1:0]  rdata_i,
  output logic [W-1:0]  byte_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] idx_q;
  logic [W-1:0]  byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      byte_q <= '0;
    end else if (stb_i) begin
      byte_q <= rdata_i;
      idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign byte_o = byte_q;

  p_tx_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && idx_q == LAST) |=> idx_q == '0);
  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> ($stable(idx_q) && $stable(byte_q)));
endmodule

// File: rtl/trace_rx.sv
module trace_rx #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [W-1:0]  byte_i,
  output logic [IW-1:0] idx_o,
  input  logic [W-1:0]  exp_byte_i,
  input  logic [IW-1:0] ext_ridx_i,
  output logic [W-1:0]  ext_rdata_o,
  output logic          done_o,
  output logic          mis_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0]           idx_q;
  logic [DEPTH-1:0][W-1:0] stage_q, stage_n, ext_q;
  logic                    acc_exp_q, acc_ext_q, acc_exp_n, acc_ext_n;
  logic                    first;

  // running differences against expected and last stored message
  always_comb begin
    first     = (idx_q == '0);
    acc_exp_n = (byte_i != exp_byte_i) | (~first & acc_exp_q);
    acc_ext_n = (byte_i != ext_q[idx_q]) | (~first & acc_ext_q);
    stage_n   = stage_q;
    stage_n[idx_q] = byte_i;
  end

  assign done_o = stb_i && (idx_q == LAST);
  assign mis_o  = acc_exp_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      stage_q   <= '0;
      ext_q     <= '0;
      acc_exp_q <= 1'b0;
      acc_ext_q <= 1'b0;
    end else if (stb_i) begin
      stage_q   <= stage_n;
      acc_exp_q <= acc_exp_n;
      acc_ext_q <= acc_ext_n;
      idx_q     <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      if (done_o && acc_ext_n) ext_q <= stage_n;
    end
  end

  assign idx_o       = idx_q;
  assign ext_rdata_o = ext_q[ext_ridx_i];

  p_rx_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && idx_q == LAST) |=> idx_q == '0);
  p_ext_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(ext_q));
endmodule

// File: rtl/trace_persist.sv
module trace_persist #(
  parameter int unsigned PERSIST = 3,
  localparam int unsigned CW     = $clog2(PERSIST + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic mis_i,
  output logic flag_o,
  output logic evt_o
);
  logic [CW-1:0] cnt_q;
  logic          flag_q, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (done_i) begin
        if (mis_i == flag_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(PERSIST - 1)) begin
          cnt_q  <= '0;
          flag_q <= ~flag_q;
          evt_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign flag_o = flag_q;
  assign evt_o  = evt_q;

  p_evt_toggle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (flag_q != $past(flag_q)));
  p_flag_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q != $past(flag_q)) |-> ($past(done_i) && evt_q));
  p_cnt_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERSIST));
endmodule

// File: rtl/trace_monitor.sv
module trace_monitor
  import trace_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PERSIST = 3,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_stb_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              rx_stb_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              mismatch_o,
  output logic              mismatch_evt_o
);
  bank_e             bank;
  logic [IDX_W-1:0]  ridx, tx_idx, rx_idx;
  logic [BYTE_W-1:0] ins_rd, ins_tx, exp_rd, exp_rx, ext_rd;
  logic              ins_we, exp_we, msg_done, msg_mis, flag;

  assign bank   = bank_e'(reg_addr_i[ADDR_W-1 -: 2]);
  assign ridx   = reg_addr_i[IDX_W-1:0];
  assign ins_we = reg_we_i && (bank == BANK_INS);
  assign exp_we = reg_we_i && (bank == BANK_EXP);

  trace_buf #(.DEPTH(DEPTH), .W(BYTE_W)) i_ins_buf (
    .clk_i, .rst_ni,
    .we_i(ins_we), .widx_i(ridx), .wdata_i(reg_wdata_i),
    .ridx_a_i(ridx), .rdata_a_o(ins_rd),
    .ridx_b_i(tx_idx), .rdata_b_o(ins_tx)
  );

  trace_buf #(.DEPTH(DEPTH), .W(BYTE_W)) i_exp_buf (
    .clk_i, .rst_ni,
    .we_i(exp_we), .widx_i(ridx), .wdata_i(reg_wdata_i),
    .ridx_a_i(ridx), .rdata_a_o(exp_rd),
    .ridx_b_i(rx_idx), .rdata_b_o(exp_rx)
  );

  trace_tx #(.DEPTH(DEPTH), .W(BYTE_W)) i_tx (
    .clk_i, .rst_ni,
    .stb_i(tx_stb_i), .idx_o(tx_idx), .rdata_i(ins_tx), .byte_o(tx_byte_o)
  );

  trace_rx #(.DEPTH(DEPTH), .W(BYTE_W)) i_rx (
    .clk_i, .rst_ni,
    .stb_i(rx_stb_i), .byte_i(rx_byte_i), .idx_o(rx_idx),
    .exp_byte_i(exp_rx), .ext_ridx_i(ridx), .ext_rdata_o(ext_rd),
    .done_o(msg_done), .mis_o(msg_mis)
  );

  trace_persist #(.PERSIST(PERSIST)) i_persist (
    .clk_i, .rst_ni,
    .done_i(msg_done), .mis_i(msg_mis), .flag_o(flag), .evt_o(mismatch_evt_o)
  );

  always_comb begin
    unique case (bank)
      BANK_INS: reg_rdata_o = ins_rd;
      BANK_EXP: reg_rdata_o = exp_rd;
      BANK_EXT: reg_rdata_o = ext_rd;
      default:  reg_rdata_o = {{(BYTE_W-1){1'b0}}, flag};
    endcase
  end

  assign mismatch_o = flag;
endmodule

// File: tb/test_trace_monitor.sv
module test_trace_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_stb = 1'b0, rx_stb = 1'b0, reg_we = 1'b0;
  logic [7:0] rx_byte = '0, reg_addr = '0, reg_wdata = '0;
  logic [7:0] tx_byte, reg_rdata;
  logic       mism, mism_evt;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       tx_pend = 1'b0;
  logic [7:0] ins_model[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_monitor i_trace_monitor (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_stb_i(tx_stb), .tx_byte_o(tx_byte),
    .rx_stb_i(rx_stb), .rx_byte_i(rx_byte),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .mismatch_o(mism), .mismatch_evt_o(mism_evt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor for the transmit path
  always @(posedge clk) tx_pend <= tx_stb;
  always @(negedge clk) begin
    if (tx_pend) begin
      if (exp_q.size() == 0) begin
        chk("R2", "unexpected tx byte", 1, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, "tx byte", tx_byte, e);
      end
    end
  end

  function automatic logic [7:0] msg_byte(input int kind, input int i);
    case (kind)
      0: return 8'h20 + 8'(i);
      1: return (i == 17) ? 8'hEE : 8'h20 + 8'(i);
      default: return 8'hA5;
    endcase
  endfunction

  task automatic reg_write(input logic [1:0] bank, input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_addr = {bank, 6'(idx)}; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(input string req, input logic [1:0] bank, input int idx, input logic [7:0] e);
    @(negedge clk);
    reg_addr = {bank, 6'(idx)};
    #1 chk(req, "register read", reg_rdata, e);
  endtask

  task automatic tx_step(input logic [7:0] e, input string req);
    @(negedge clk);
    tx_stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    tx_stb = 1'b0;
  endtask

  // leaves the caller at the negedge right after the last strobe edge
  task automatic rx_range(input int kind, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      rx_stb = 1'b1; rx_byte = msg_byte(kind, i);
    end
    @(negedge clk);
    rx_stb = 1'b0;
  endtask

  task automatic flag_chk(input string req, input logic f, input logic ev);
    chk(req, "mismatch flag", mism, f);
    chk("R10", "mismatch event", mism_evt, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", "run timed out", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "flag", mism, 0);
    chk("R1", "event", mism_evt, 0);
    chk("R1", "tx byte", tx_byte, 0);
    reg_chk("R1", 2'd0, 0, 8'h00);
    reg_chk("R1", 2'd1, 63, 8'h00);
    reg_chk("R1", 2'd2, 10, 8'h00);
    reg_chk("R1", 2'd3, 0, 8'h00);

    // R3 load insert buffer and read back
    for (int i = 0; i < 64; i++) begin
      ins_model[i] = 8'hC0 + 8'(i);
      reg_write(2'd0, i, ins_model[i]);
    end
    reg_chk("R3", 2'd0, 37, 8'hE5);

    // R2 one full pass plus wrap
    for (int i = 0; i < 66; i++) tx_step(ins_model[i % 64], "R2");
    tx_step(ins_model[2], "R2");
    // index now 3; run to index 2 again
    for (int i = 3; i < 64; i++) tx_step(ins_model[i], "R2");
    tx_step(ins_model[0], "R2");
    tx_step(ins_model[1], "R2");
    // R11 collision on entry 2
    @(negedge clk);
    tx_stb = 1'b1; reg_we = 1'b1; reg_addr = {2'd0, 6'd2}; reg_wdata = 8'h5A;
    exp_q.push_back(ins_model[2]); tag_q.push_back("R11");
    @(negedge clk);
    tx_stb = 1'b0; reg_we = 1'b0;
    ins_model[2] = 8'h5A;
    for (int i = 3; i < 64; i++) tx_step(ins_model[i], "R2");
    tx_step(ins_model[0], "R11");
    tx_step(ins_model[1], "R11");
    tx_step(ins_model[2], "R11");
    @(negedge clk);
    chk("R2", "scoreboard drained", exp_q.size(), 0);

    // expected buffer
    for (int i = 0; i < 64; i++) reg_write(2'd1, i, msg_byte(0, i));
    reg_chk("R3", 2'd1, 33, 8'h41);

    // R6 writes to extract and status ignored
    reg_write(2'd2, 5, 8'hFF);
    reg_chk("R6", 2'd2, 5, 8'h00);
    reg_write(2'd3, 0, 8'hFF);
    reg_chk("R6", 2'd3, 0, 8'h00);
    chk("R6", "flag after status write", mism, 0);

    // matching message
    rx_range(0, 0, 63);
    flag_chk("R8", 0, 0);
    reg_chk("R5", 2'd2, 5, 8'h25);

    // R5 half message not visible
    rx_range(2, 0, 31);
    reg_chk("R5", 2'd2, 5, 8'h25);
    rx_range(2, 32, 63);
    flag_chk("R7", 0, 0);
    reg_chk("R4", 2'd2, 0, 8'hA5);
    reg_chk("R5", 2'd2, 63, 8'hA5);

    // R9 non-consecutive mismatches
    rx_range(1, 0, 63);
    flag_chk("R9", 0, 0);
    rx_range(0, 0, 63);
    flag_chk("R9", 0, 0);

    // R7 three in a row
    rx_range(1, 0, 63);
    flag_chk("R7", 0, 0);
    rx_range(1, 0, 63);
    flag_chk("R7", 0, 0);
    rx_range(1, 0, 63);
    flag_chk("R7", 1, 1);
    @(negedge clk);
    flag_chk("R10", 1, 0);
    reg_chk("R3", 2'd3, 0, 8'h01);
    reg_chk("R5", 2'd2, 17, 8'hEE);

    // R8 three matches clear
    rx_range(0, 0, 63);
    flag_chk("R8", 1, 0);
    rx_range(0, 0, 63);
    flag_chk("R8", 1, 0);
    rx_range(0, 0, 63);
    flag_chk("R8", 0, 1);
    @(negedge clk);
    flag_chk("R10", 0, 0);
    reg_chk("R5", 2'd2, 17, 8'h31);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule